// File: doc/BRIEF.md
# Serial threshold and front-end configuration loader

This block holds the digital codes for a bank of trigger threshold converters and a short front-end configuration word. Both are loaded over serial ports, each with its own clock. The threshold port shifts one bit per rising edge of its serial clock into a long chain holding one 20-bit code per threshold. A separate transfer strobe copies the whole chain into a bank of held registers in one step. The held codes therefore stay constant while a new set is shifted in. Each held code is split into a coarse main field and a fine trim field.

The configuration port shifts an 11-bit word. The word is decoded at once into an analog source select, four gain-stage enables and a 5-bit multiplicity threshold. Each chain drives its oldest bit onto an echo output, so the loaded data can be read back and compared. An asynchronous active-low clear zeroes the held threshold codes and the configuration chain. It leaves the threshold shift chain untouched.

Top module: `serial_thresh_loader`

## Requirements
- R1: On every rising edge of `sclk_i` the threshold chain takes one bit from `thr_din_i`. Chain position p holds the p-th bit of the last 1280 shifted in, with position 0 shifted first. Code k (0-based) occupies positions 20k to 20k+19.
- R2: Bit j (0..11) of the main field of code k, `thr_main_o[12k+j]`, equals chain position 20k+j, so the main field is sent LSB first.
- R3: Bit j (0..7) of the trim field of code k, `thr_trim_o[8k+j]`, equals chain position 20k+12+j, so the trim field follows the main field LSB first.
- R4: The held codes change only on a rising edge of `dclk_i`, which copies the whole chain at once. Shifting alone never alters `thr_main_o` or `thr_trim_o`.
- R5: The bit on `thr_dout_o` just before `sclk_i` edge n is the bit captured from `thr_din_i` at edge n-1280.
- R6: While `rst_ni` is low, all held codes, the configuration word and `mult_thr_o` read zero. The threshold shift chain keeps its contents through a clear.
- R7: The configuration chain is 11 bits long. Configuration bit b is the b-th of the last 11 bits shifted on `cfg_clk_i` rising edges, with bit 0 shifted first.
- R8: `src_sel_o` is 0 (SCA) when bit 0 is 0, 1 (CAL) when bit 0 is 1 and bit 1 is 0, and 2 (DAC) when both are 1. The value 3 never appears.
- R9: `gain_en_o[i]` equals configuration bit 2+i, for i from 0 to 3.
- R10: `mult_thr_o` is configuration bits 6 to 10 with bit 6 as the MSB: `mult_thr_o[4-i]` equals bit 6+i.
- R11: The bit on `cfg_sout_o` just before `cfg_clk_i` edge n is the bit shifted in at edge n-11, once 11 edges have passed since the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Threshold chain shift clock |
| dclk_i | input | 1 | Transfer strobe, chain to held codes on rising edge |
| rst_ni | input | 1 | Asynchronous active-low register clear |
| thr_din_i | input | 1 | Threshold chain serial data |
| thr_dout_o | output | 1 | Threshold chain echo |
| cfg_clk_i | input | 1 | Configuration chain shift clock |
| cfg_sin_i | input | 1 | Configuration chain serial data |
| cfg_sout_o | output | 1 | Configuration chain echo |
| thr_main_o | output | 768 | Held main fields, 12 bits per code, code 0 lowest |
| thr_trim_o | output | 512 | Held trim fields, 8 bits per code, code 0 lowest |
| src_sel_o | output | 2 | Analog source select: 0 SCA, 1 CAL, 2 DAC |
| gain_en_o | output | 4 | Gain-stage enables |
| mult_thr_o | output | 5 | Multiplicity threshold |

## Verification
The hold-stability property assumes that every `dclk_i` pulse stays high across at least one rising edge of `sclk_i`. Without that, a short strobe between two shift edges would go unseen by a check clocked on that edge. The bench raises the strobe on a falling edge of `sclk_i` and lowers it one full period later. The configuration properties assume `cfg_sin_i` is steady at each `cfg_clk_i` edge. The bench sets the data half a phase before raising the clock. The clear is applied and released only on falling edges of `sclk_i`, and only while the configuration clock is idle.

// File: rtl/thr_load_pkg.sv
package thr_load_pkg;
  localparam int CFG_W    = 11;
  localparam int SRC_BIT  = 0;  // 0: SCA, 1: CAL or DAC
  localparam int DAC_BIT  = 1;  // with SRC_BIT set: 0 CAL, 1 DAC
  localparam int GAIN_LSB = 2;
  localparam int GAIN_N   = 4;
  localparam int MULT_LSB = 6;  // MSB of multiplicity sits here
  localparam int MULT_W   = 5;

  typedef enum logic [1:0] {
    SRC_SCA = 2'd0,
    SRC_CAL = 2'd1,
    SRC_DAC = 2'd2
  } src_sel_e;
endpackage

// File: rtl/thr_shift_chain.sv
module thr_shift_chain #(
  parameter int LEN = 1280
) (
  input  logic           clk_i,
  input  logic           d_i,
  output logic [LEN-1:0] pos_o,
  output logic           echo_o
);
  logic [LEN-1:0] sreg_q;

  // position LEN-1 is newest; position 0 is oldest and drives the echo
  always_ff @(posedge clk_i) begin
    sreg_q <= {d_i, sreg_q[LEN-1:1]};
  end

  assign pos_o  = sreg_q;
  assign echo_o = sreg_q[0];
endmodule

// File: rtl/thr_hold_bank.sv
module thr_hold_bank #(
  parameter int NUM_CODES = 64,
  parameter int MAIN_W    = 12,
  parameter int TRIM_W    = 8
) (
  input  logic                          strobe_i,
  input  logic                          rst_ni,
  input  logic [NUM_CODES*(MAIN_W+TRIM_W)-1:0] chain_i,
  output logic [NUM_CODES*MAIN_W-1:0]   main_o,
  output logic [NUM_CODES*TRIM_W-1:0]   trim_o
);
  localparam int CODE_W = MAIN_W + TRIM_W;
  localparam int LEN    = NUM_CODES * CODE_W;

  logic [LEN-1:0] held_q;

  always_ff @(posedge strobe_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= chain_i;
  end

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
    assign main_o[k*MAIN_W +: MAIN_W] = held_q[k*CODE_W +: MAIN_W];
    assign trim_o[k*TRIM_W +: TRIM_W] = held_q[k*CODE_W+MAIN_W +: TRIM_W];
  end
endmodule

// File: rtl/cfg_chain.sv
module cfg_chain
  import thr_load_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sin_i,
  output logic              sout_o,
  output logic [1:0]        src_o,
  output logic [GAIN_N-1:0] gain_o,
  output logic [MULT_W-1:0] mult_o
);
  logic [CFG_W-1:0] bits_q;  // bits_q[b] = configuration bit b
  src_sel_e         src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= {sin_i, bits_q[CFG_W-1:1]};
  end

  assign sout_o = bits_q[0];

  always_comb begin
    if (!bits_q[SRC_BIT])      src = SRC_SCA;
    else if (!bits_q[DAC_BIT]) src = SRC_CAL;
    else                       src = SRC_DAC;
  end
  assign src_o = src;

  for (genvar i = 0; i < GAIN_N; i++) begin : g_gain
    assign gain_o[i] = bits_q[GAIN_LSB+i];
  end

  for (genvar i = 0; i < MULT_W; i++) begin : g_mult
    assign mult_o[MULT_W-1-i] = bits_q[MULT_LSB+i];
  end
endmodule

// File: rtl/serial_thresh_loader.sv
module serial_thresh_loader
  import thr_load_pkg::*;
#(
  parameter int NUM_CODES = 64,
  parameter int MAIN_W    = 12,
  parameter int TRIM_W    = 8
) (
  input  logic                        sclk_i,
  input  logic                        dclk_i,
  input  logic                        rst_ni,
  input  logic                        thr_din_i,
  output logic                        thr_dout_o,
  input  logic                        cfg_clk_i,
  input  logic                        cfg_sin_i,
  output logic                        cfg_sout_o,
  output logic [NUM_CODES*MAIN_W-1:0] thr_main_o,
  output logic [NUM_CODES*TRIM_W-1:0] thr_trim_o,
  output logic [1:0]                  src_sel_o,
  output logic [GAIN_N-1:0]           gain_en_o,
  output logic [MULT_W-1:0]           mult_thr_o
);
  localparam int CODE_W    = MAIN_W + TRIM_W;
  localparam int CHAIN_LEN = NUM_CODES * CODE_W;

  logic [CHAIN_LEN-1:0] chain;

  thr_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk_i  (sclk_i),
    .d_i    (thr_din_i),
    .pos_o  (chain),
    .echo_o (thr_dout_o)
  );

  thr_hold_bank #(
    .NUM_CODES (NUM_CODES),
    .MAIN_W    (MAIN_W),
    .TRIM_W    (TRIM_W)
  ) u_hold (
    .strobe_i (dclk_i),
    .rst_ni   (rst_ni),
    .chain_i  (chain),
    .main_o   (thr_main_o),
    .trim_o   (thr_trim_o)
  );

  cfg_chain u_cfg (
    .clk_i  (cfg_clk_i),
    .rst_ni (rst_ni),
    .sin_i  (cfg_sin_i),
    .sout_o (cfg_sout_o),
    .src_o  (src_sel_o),
    .gain_o (gain_en_o),
    .mult_o (mult_thr_o)
  );
endmodule

// File: rtl/thr_load_chk.sv
module thr_load_chk
  import thr_load_pkg::*;
#(
  parameter int NUM_CODES = 64,
  parameter int MAIN_W    = 12,
  parameter int TRIM_W    = 8
) (
  input logic                        sclk_i,
  input logic                        dclk_i,
  input logic                        rst_ni,
  input logic                        cfg_clk_i,
  input logic                        cfg_sin_i,
  input logic                        cfg_sout_o,
  input logic [NUM_CODES*MAIN_W-1:0] thr_main_o,
  input logic [NUM_CODES*TRIM_W-1:0] thr_trim_o,
  input logic [1:0]                  src_sel_o,
  input logic [GAIN_N-1:0]           gain_en_o,
  input logic [MULT_W-1:0]           mult_thr_o
);
  localparam int CNT_W = $clog2(CFG_W + 1);

  logic [CNT_W-1:0] cfg_cnt_q;  // cfg edges since clear, saturating

  always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cfg_cnt_q <= '0;
    else if (cfg_cnt_q != CNT_W'(CFG_W)) cfg_cnt_q <= cfg_cnt_q + 1'b1;
  end

  // R6
  always @(posedge sclk_i) begin
    if (!rst_ni) begin
      clr_state_chk: assert (thr_main_o == '0 && thr_trim_o == '0 &&
                             mult_thr_o == '0 && gain_en_o == '0 &&
                             src_sel_o == 2'd0);
    end
  end

  // R4
  held_stable_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!dclk_i && !$past(dclk_i)) |-> ($stable(thr_main_o) && $stable(thr_trim_o)));

  // R11
  cfg_echo_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (cfg_cnt_q == CNT_W'(CFG_W)) |-> (cfg_sout_o == $past(cfg_sin_i, CFG_W)));

  // R10
  mult_ripple_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (cfg_cnt_q != '0) |->
      (mult_thr_o == {$past(mult_thr_o[MULT_W-2:0]), $past(cfg_sin_i)}));

  // R9
  gain_ripple_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (cfg_cnt_q != '0) |->
      (gain_en_o == {$past(mult_thr_o[MULT_W-1]), $past(gain_en_o[GAIN_N-1:1])}));

  // R8
  src_legal_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    src_sel_o != 2'd3);

  // R8
  src_cal_next_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (cfg_cnt_q != '0 && $past(src_sel_o) == 2'd1) |-> (src_sel_o == 2'd0));

  // R8
  src_dac_next_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (cfg_cnt_q != '0 && $past(src_sel_o) == 2'd2) |->
      (src_sel_o == ($past(gain_en_o[0]) ? 2'd2 : 2'd1)));
endmodule

bind serial_thresh_loader thr_load_chk #(
  .NUM_CODES (NUM_CODES),
  .MAIN_W    (MAIN_W),
  .TRIM_W    (TRIM_W)
) u_chk (.*);

// File: tb/serial_thresh_loader_bench.sv
module serial_thresh_loader_bench;
  localparam int NUM_CODES = 64;
  localparam int MAIN_W    = 12;
  localparam int TRIM_W    = 8;
  localparam int CODE_W    = MAIN_W + TRIM_W;
  localparam int LEN       = NUM_CODES * CODE_W;
  localparam int CFG_W     = 11;

  logic sclk = 1'b0, dclk = 1'b0, rst_n = 1'b1, din = 1'b0;
  logic cfg_clk = 1'b0, cfg_sin = 1'b0;
  logic dout, cfg_sout;
  logic [NUM_CODES*MAIN_W-1:0] main_w;
  logic [NUM_CODES*TRIM_W-1:0] trim_w;
  logic [1:0] src;
  logic [3:0] gain;
  logic [4:0] mult;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  bit pat [0:LEN-1];
  bit held_exp [0:LEN-1];
  bit s_hist [0:4095];
  int s_edges = 0;
  bit dout_en = 0;
  bit c_hist [0:1023];
  int c_edges = 0;

  always #4 sclk = ~sclk;  // 125 MHz

  serial_thresh_loader u_serial_thresh_loader (
    .sclk_i(sclk), .dclk_i(dclk), .rst_ni(rst_n), .thr_din_i(din),
    .thr_dout_o(dout), .cfg_clk_i(cfg_clk), .cfg_sin_i(cfg_sin),
    .cfg_sout_o(cfg_sout), .thr_main_o(main_w), .thr_trim_o(trim_w),
    .src_sel_o(src), .gain_en_o(gain), .mult_thr_o(mult)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge sclk) begin
    s_hist[s_edges % 4096] = din;
    s_edges++;
  end

  // R5: echo compared between edges
  always @(negedge sclk) begin
    if (dout_en && s_edges >= LEN)
      chk(dout == s_hist[(s_edges - LEN) % 4096], "R5", "thr echo",
          32'(dout), 32'(s_hist[(s_edges - LEN) % 4096]));
  end

  function automatic logic [MAIN_W-1:0] exp_main(input int k);
    logic [MAIN_W-1:0] v;
    for (int j = 0; j < MAIN_W; j++) v[j] = held_exp[k*CODE_W + j];
    return v;
  endfunction

  function automatic logic [TRIM_W-1:0] exp_trim(input int k);
    logic [TRIM_W-1:0] v;
    for (int j = 0; j < TRIM_W; j++) v[j] = held_exp[k*CODE_W + MAIN_W + j];
    return v;
  endfunction

  task automatic check_held(input string req);
    for (int k = 0; k < NUM_CODES; k++) begin
      chk(main_w[k*MAIN_W +: MAIN_W] == exp_main(k), req, "main field",
          32'(main_w[k*MAIN_W +: MAIN_W]), 32'(exp_main(k)));
      chk(trim_w[k*TRIM_W +: TRIM_W] == exp_trim(k), req, "trim field",
          32'(trim_w[k*TRIM_W +: TRIM_W]), 32'(exp_trim(k)));
    end
  endtask

  task automatic check_cfg_zero(input string req);
    chk(main_w == '0 && trim_w == '0, req, "held codes cleared",
        32'(main_w[31:0] | trim_w[31:0]), 32'd0);
    chk(mult == 5'd0, req, "mult cleared", 32'(mult), 32'd0);
    chk(gain == 4'd0 && src == 2'd0, req, "cfg cleared", 32'({gain, src}), 32'd0);
    chk(cfg_sout == 1'b0, req, "cfg echo cleared", 32'(cfg_sout), 32'd0);
  endtask

  // rst_at >= 0 pulses the clear low for two periods mid-load
  task automatic load_thr(input int rst_at);
    for (int p = 0; p < LEN; p++) begin
      @(negedge sclk);
      din = pat[p];
      if (p == rst_at) rst_n = 1'b0;
      if (p == rst_at + 1) begin
        check_cfg_zero("R6");
        for (int q = 0; q < LEN; q++) held_exp[q] = 1'b0;
        c_edges = 0;
      end
      if (p == rst_at + 2) rst_n = 1'b1;
    end
    @(negedge sclk);
    dclk = 1'b1;
    din = 1'($urandom);
    @(negedge sclk);
    dclk = 1'b0;
    for (int q = 0; q < LEN; q++) held_exp[q] = pat[q];
  endtask

  task automatic fill_codes(input int mode);
    for (int k = 0; k < NUM_CODES; k++) begin
      logic [MAIN_W-1:0] m;
      logic [TRIM_W-1:0] t;
      case (mode)
        0: begin m = MAIN_W'(k * 37 + 5); t = TRIM_W'(~k); end
        1: begin m = '1; t = '0; end
        default: begin m = MAIN_W'($urandom); t = TRIM_W'($urandom); end
      endcase
      for (int j = 0; j < MAIN_W; j++) pat[k*CODE_W + j] = m[j];
      for (int j = 0; j < TRIM_W; j++) pat[k*CODE_W + MAIN_W + j] = t[j];
    end
  endtask

  task automatic cfg_clock(input bit b);
    cfg_sin = b;
    #3 cfg_clk = 1'b1;
    c_hist[c_edges % 1024] = b;
    c_edges++;
    #3 cfg_clk = 1'b0;
    #2;
    // R11
    if (c_edges >= CFG_W)
      chk(cfg_sout == c_hist[(c_edges - CFG_W) % 1024], "R11", "cfg echo",
          32'(cfg_sout), 32'(c_hist[(c_edges - CFG_W) % 1024]));
  endtask

  task automatic cfg_load(input logic [CFG_W-1:0] w);
    logic [1:0] es;
    logic [4:0] em;
    for (int b = 0; b < CFG_W; b++) cfg_clock(w[b]);
    es = !w[0] ? 2'd0 : (!w[1] ? 2'd1 : 2'd2);
    for (int i = 0; i < 5; i++) em[4-i] = w[6+i];
    chk(src == es, "R8", "source select", 32'(src), 32'(es));
    chk(gain == w[5:2], "R9", "gain enables", 32'(gain), 32'(w[5:2]));
    chk(mult == em, "R10", "multiplicity", 32'(mult), 32'(em));
    // R7: the whole word lands in bit order
    chk({mult, gain, src} == {em, w[5:2], es}, "R7", "cfg word",
        32'({mult, gain, src}), 32'({em, w[5:2], es}));
  endtask

  initial begin
    void'($urandom(32'd20231));
    #2 rst_n = 1'b0;
    repeat (3) @(negedge sclk);
    check_cfg_zero("R6");
    rst_n = 1'b1;

    dout_en = 1;
    // R1 R2 R3: directed layout, then all-ones main, then random
    fill_codes(0); load_thr(-10); check_held("R2");
    fill_codes(1); load_thr(-10); check_held("R3");
    fill_codes(2); load_thr(-10); check_held("R1");

    // R4: keep shifting random data without a strobe
    for (int i = 0; i < 300; i++) begin
      @(negedge sclk);
      din = 1'($urandom);
    end
    check_held("R4");

    // R6: clear mid-load, chain survives
    fill_codes(2); load_thr(600); check_held("R6");

    // configuration chain
    cfg_load(11'b000_0000_0000);
    cfg_load(11'b000_0000_0001);
    cfg_load(11'b000_0000_0011);
    cfg_load(11'b000_0000_0010);
    cfg_load(11'b000_0100_0000);
    cfg_load(11'b100_0000_0000);
    cfg_load(11'b000_0011_1100);
    for (int i = 0; i < 12; i++) cfg_load(CFG_W'($urandom));

    // R6: clear zeroes config, then reload
    @(negedge sclk); rst_n = 1'b0;
    @(negedge sclk); check_cfg_zero("R6"); c_edges = 0;
    for (int q = 0; q < LEN; q++) held_exp[q] = 1'b0;
    rst_n = 1'b1;
    cfg_load(11'b101_0110_1011);

    fill_codes(2); load_thr(-10); check_held("R1");
    dout_en = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule